// File: doc/BRIEF.md
# Memory Partition Request Steering with Timed Delay Stages

This block sits at the entry of one memory partition. Requests arrive from the interconnect. Each one is routed either to the partition cache or straight to the DRAM path. Requests marked as texture go directly into an ingress FIFO. All other requests first wait in a timed delay queue before they join that FIFO.

The head of the ingress FIFO takes one of two paths. It bypasses the cache when the cache is off, or when texture-only caching is selected and the request is not texture. Otherwise it is offered to the cache, which answers in the same cycle. The answer decides whether the request is popped, whether it produces a reply, or whether it stays at the head to try again.

Traffic headed for DRAM passes through a cache-to-DRAM FIFO and then a second timed delay queue. From there it is released to DRAM. Each timed entry carries a ready stamp taken from a free-running cycle counter. Both latencies are run-time inputs. The ingress FIFO, the cache-to-DRAM FIFO and the two delay queues each have their own depth parameter.

Top module: `part_req_steer`

## Requirements
- R1: A request with `req_tex`=1, presented while `part_full` is low, is written into the ingress FIFO. With no request ahead of it, it appears at the cache port in the next cycle.
- R2: A request with `req_tex`=0, presented while `rop_full` is low, waits in the ingress delay queue. It leaves once at least `cfg_rop_lat` cycles have passed (never fewer than one), and only when the ingress FIFO has room. Requests leave in arrival order. A texture arrival in the same cycle takes the ingress slot first.
- R3: The ingress head is acted on only while the cache-to-DRAM FIFO has room. It goes to the DRAM path without touching the cache when `cfg_cache_en`=0, or when `cfg_tex_only`=1 and the request is not texture.
- R4: A cache access (`cache_req_valid`) is issued only while `rsp_full` is low.
- R5: `cache_status` encoding: 2'b00 means hit, 2'b01 means miss accepted, and 2'b10 or 2'b11 means reservation fail. On a hit with `cache_wr_sent`=0, the request is popped and replied on `rsp_id`, unless its writeback flag is set, in which case it is popped with no reply.
- R6: A hit with `cache_wr_sent`=1, or an accepted miss, pops the request and gives no reply.
- R7: On a reservation fail the request stays at the head. It is offered again in the next cycle in which an access is allowed, and no request behind it passes it.
- R8: While `dram_full` is low, the cache-to-DRAM FIFO moves one entry per cycle into the DRAM delay queue. An entry is released on `dram_valid` once at least `cfg_dram_lat` cycles have passed (never fewer than one) and `dram_full` is low, in order. A texture request on the bypass path reaches DRAM 2+max(`cfg_dram_lat`,1) cycles after it is accepted. A non-texture request adds max(`cfg_rop_lat`,1) to that.
- R9: `part_full` is high exactly when the ingress FIFO holds `IC_DEPTH` entries.
- R10: Ready stamps wrap modulo 2^`TS_W` and are compared by signed difference. Latencies below 2^(`TS_W`-1) are kept exactly across counter wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cache_en | input | 1 | Cache in use |
| cfg_tex_only | input | 1 | Only texture requests use the cache |
| cfg_rop_lat | input | LAT_W | Delay before ingress for non-texture requests |
| cfg_dram_lat | input | LAT_W | Delay before DRAM issue |
| req_valid | input | 1 | Incoming request |
| req_id | input | ID_W | Request tag |
| req_tex | input | 1 | Request is texture |
| req_wrbk | input | 1 | Request is a first-level writeback |
| part_full | output | 1 | Ingress FIFO full |
| rop_full | output | 1 | Ingress delay queue full |
| cache_req_valid | output | 1 | Cache access this cycle |
| cache_req_id | output | ID_W | Tag of the access |
| cache_req_tex | output | 1 | Texture flag of the access |
| cache_req_wrbk | output | 1 | Writeback flag of the access |
| cache_status | input | 2 | Same-cycle cache outcome |
| cache_wr_sent | input | 1 | Cache sent a write downstream |
| cache_rd_sent | input | 1 | Cache sent a read downstream |
| rsp_valid | output | 1 | Push into reply FIFO |
| rsp_id | output | ID_W | Reply tag |
| rsp_full | input | 1 | Reply FIFO full |
| dram_valid | output | 1 | Push into DRAM |
| dram_id | output | ID_W | DRAM request tag |
| dram_tex | output | 1 | Texture flag toward DRAM |
| dram_wrbk | output | 1 | Writeback flag toward DRAM |
| dram_full | input | 1 | DRAM cannot accept |

## Verification
A corrupted ready stamp or a bad counter compare shows up as a change in the cycle distance from request acceptance to `dram_valid` or `rsp_valid`. That distance is exact, so the error appears with the very first request. A pointer or count error in any queue shows at the ports within one traversal: tags come out reordered, duplicated or missing, or `part_full` does not match the number of stalled texture requests. A wrong pop decision on a cache outcome shows the next cycle, either as a second access with a different tag after a reservation fail or as an extra or missing reply.

// File: rtl/steer_pkg.sv
`timescale 1ns/1ps
package steer_pkg;
    typedef enum logic [1:0] {
        CST_HIT   = 2'b00,
        CST_MISS  = 2'b01,
        CST_RFAIL = 2'b10,
        CST_RSVD  = 2'b11
    } cache_st_e;
endpackage

// File: rtl/steer_fifo.sv
`timescale 1ns/1ps
module steer_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic         empty,
    output logic [W-1:0] head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = bump(st_q.wr);
        end
        if (pop) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign head  = st_q.mem[st_q.rd];

    // R9: the owner never writes into a full buffer
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R3: the owner never pops an empty buffer
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/steer_delay_q.sv
`timescale 1ns/1ps
module steer_delay_q #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int TS_W  = 32,
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  now,
    input  logic [LAT_W-1:0] lat,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic             full,
    output logic             due,
    output logic [W-1:0]     head
);
    localparam int SW = TS_W + W;

    logic [SW-1:0]   slot_in;
    logic [SW-1:0]   slot_out;
    logic            empty;
    logic [TS_W-1:0] stamp;
    logic [TS_W-1:0] age;

    assign slot_in = {now + TS_W'(lat), push_data};

    steer_fifo #(.W(SW), .DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (slot_in),
        .pop       (pop),
        .full      (full),
        .empty     (empty),
        .head      (slot_out)
    );

    // Ready when now - stamp is non-negative as a signed value (R10)
    assign stamp = slot_out[SW-1:W];
    assign age   = now - stamp;
    assign due   = !empty && !age[TS_W-1];
    assign head  = slot_out[W-1:0];

    // R2, R8: an entry only leaves once its stamp has been reached
    assert_release_when_due_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (!empty && !age[TS_W-1]));
endmodule

// File: rtl/part_req_steer.sv
`timescale 1ns/1ps
module part_req_steer
    import steer_pkg::*;
#(
    parameter int ID_W      = 8,
    parameter int IC_DEPTH  = 4,
    parameter int CD_DEPTH  = 4,
    parameter int ROP_DEPTH = 8,
    parameter int DQ_DEPTH  = 8,
    parameter int TS_W      = 32,
    parameter int LAT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_cache_en,
    input  logic             cfg_tex_only,
    input  logic [LAT_W-1:0] cfg_rop_lat,
    input  logic [LAT_W-1:0] cfg_dram_lat,
    input  logic             req_valid,
    input  logic [ID_W-1:0]  req_id,
    input  logic             req_tex,
    input  logic             req_wrbk,
    output logic             part_full,
    output logic             rop_full,
    output logic             cache_req_valid,
    output logic [ID_W-1:0]  cache_req_id,
    output logic             cache_req_tex,
    output logic             cache_req_wrbk,
    input  logic [1:0]       cache_status,
    input  logic             cache_wr_sent,
    input  logic             cache_rd_sent,
    output logic             rsp_valid,
    output logic [ID_W-1:0]  rsp_id,
    input  logic             rsp_full,
    output logic             dram_valid,
    output logic [ID_W-1:0]  dram_id,
    output logic             dram_tex,
    output logic             dram_wrbk,
    input  logic             dram_full
);
    localparam int IW = ID_W + 2;

    typedef struct packed {
        logic            wrbk;
        logic            tex;
        logic [ID_W-1:0] id;
    } item_t;

    typedef struct packed {
        logic [TS_W-1:0] now;
    } top_st_t;

    typedef struct packed {
        logic  rop_push;
        logic  rop_pop;
        logic  ic_push;
        item_t ic_din;
        logic  ic_pop;
        logic  cd_push;
        logic  cd_pop;
        logic  dq_push;
        logic  dq_pop;
        logic  acc;
        logic  hit;
        logic  rsp;
    } ctl_t;

    top_st_t st_d, st_q;
    ctl_t    ctl;

    item_t in_item, rop_head, ic_head, cd_head, dq_head;
    logic  rop_due, rop_full_w;
    logic  ic_full, ic_empty;
    logic  cd_full, cd_empty;
    logic  dq_due, dq_full;
    cache_st_e st_w;

    assign in_item = '{wrbk: req_wrbk, tex: req_tex, id: req_id};
    assign st_w    = cache_st_e'(cache_status);

    // Ingress delay queue for non-texture requests
    steer_delay_q #(.W(IW), .DEPTH(ROP_DEPTH), .TS_W(TS_W), .LAT_W(LAT_W)) u_rop_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .now       (st_q.now),
        .lat       (cfg_rop_lat),
        .push      (ctl.rop_push),
        .push_data (in_item),
        .pop       (ctl.rop_pop),
        .full      (rop_full_w),
        .due       (rop_due),
        .head      (rop_head)
    );

    // Ingress FIFO in front of the cache
    steer_fifo #(.W(IW), .DEPTH(IC_DEPTH)) u_ic_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ctl.ic_push),
        .push_data (ctl.ic_din),
        .pop       (ctl.ic_pop),
        .full      (ic_full),
        .empty     (ic_empty),
        .head      (ic_head)
    );

    // Cache-to-DRAM FIFO
    steer_fifo #(.W(IW), .DEPTH(CD_DEPTH)) u_cd_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ctl.cd_push),
        .push_data (ic_head),
        .pop       (ctl.cd_pop),
        .full      (cd_full),
        .empty     (cd_empty),
        .head      (cd_head)
    );

    // DRAM issue delay queue
    steer_delay_q #(.W(IW), .DEPTH(DQ_DEPTH), .TS_W(TS_W), .LAT_W(LAT_W)) u_dram_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .now       (st_q.now),
        .lat       (cfg_dram_lat),
        .push      (ctl.dq_push),
        .push_data (cd_head),
        .pop       (ctl.dq_pop),
        .full      (dq_full),
        .due       (dq_due),
        .head      (dq_head)
    );

    always_comb begin
        logic tex_in;
        logic examine;
        logic bypass;

        st_d     = st_q;
        st_d.now = st_q.now + 1'b1;
        ctl      = '0;

        // Ingress side: texture direct, others through the delay queue
        tex_in       = req_valid && req_tex && !ic_full;
        ctl.rop_push = req_valid && !req_tex && !rop_full_w;
        ctl.rop_pop  = rop_due && !ic_full && !tex_in;
        ctl.ic_push  = tex_in || ctl.rop_pop;
        ctl.ic_din   = tex_in ? in_item : rop_head;

        // Cache stage
        examine = !ic_empty && !cd_full;
        bypass  = !cfg_cache_en || (cfg_tex_only && !ic_head.tex);
        ctl.cd_push = examine && bypass;
        ctl.acc     = examine && !bypass && !rsp_full;
        ctl.hit     = (st_w == CST_HIT);
        if (ctl.cd_push) begin
            ctl.ic_pop = 1'b1;
        end else if (ctl.acc) begin
            ctl.ic_pop = ctl.hit || (st_w == CST_MISS);
            ctl.rsp    = ctl.hit && !cache_wr_sent && !ic_head.wrbk;
        end

        // DRAM side
        ctl.dq_push = !cd_empty && !dq_full && !dram_full;
        ctl.cd_pop  = ctl.dq_push;
        ctl.dq_pop  = dq_due && !dram_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign part_full       = ic_full;
    assign rop_full        = rop_full_w;
    assign cache_req_valid = ctl.acc;
    assign cache_req_id    = ic_head.id;
    assign cache_req_tex   = ic_head.tex;
    assign cache_req_wrbk  = ic_head.wrbk;
    assign rsp_valid       = ctl.rsp;
    assign rsp_id          = ic_head.id;
    assign dram_valid      = ctl.dq_pop;
    assign dram_id         = dq_head.id;
    assign dram_tex        = dq_head.tex;
    assign dram_wrbk       = dq_head.wrbk;

    // R4: no reply is pushed into a full reply FIFO
    assert_reply_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !rsp_full);
    // R8: nothing is pushed into a full DRAM
    assert_dram_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dram_valid |-> !dram_full);
    // R7: after a reservation fail the next access carries the same tag
    assert_retry_same_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_req_valid && st_w != CST_HIT && st_w != CST_MISS)
        |=> (!cache_req_valid || cache_req_id == $past(cache_req_id)));
    // R5: a hit never reports a read sent downstream
    assert_hit_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_req_valid && st_w == CST_HIT) |-> !cache_rd_sent);
    // R9: a full ingress FIFO stays full while its head does not move
    assert_full_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (part_full && !ctl.ic_pop) |=> part_full);
endmodule

// File: tb/test_part_req_steer.sv
`timescale 1ns/1ps
module test_part_req_steer;
    localparam int ID_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cache_en = 1'b0;
    logic        cfg_tex_only = 1'b0;
    logic [15:0] cfg_rop_lat = 16'd4;
    logic [15:0] cfg_dram_lat = 16'd3;
    logic        req_valid = 1'b0;
    logic [ID_W-1:0] req_id = '0;
    logic        req_tex = 1'b0;
    logic        req_wrbk = 1'b0;
    logic        part_full, rop_full;
    logic        cache_req_valid;
    logic [ID_W-1:0] cache_req_id;
    logic        cache_req_tex, cache_req_wrbk;
    logic [1:0]  cache_status;
    logic        cache_wr_sent;
    logic        cache_rd_sent;
    logic        rsp_valid;
    logic [ID_W-1:0] rsp_id;
    logic        rsp_full = 1'b0;
    logic        dram_valid;
    logic [ID_W-1:0] dram_id;
    logic        dram_tex, dram_wrbk;
    logic        dram_full = 1'b0;

    always #4 clk = ~clk;

    part_req_steer #(.ID_W(ID_W), .IC_DEPTH(4), .CD_DEPTH(4), .ROP_DEPTH(8),
                     .DQ_DEPTH(8), .TS_W(8), .LAT_W(16)) i_part_req_steer (
        .clk(clk), .rst_n(rst_n), .cfg_cache_en(cfg_cache_en), .cfg_tex_only(cfg_tex_only),
        .cfg_rop_lat(cfg_rop_lat), .cfg_dram_lat(cfg_dram_lat),
        .req_valid(req_valid), .req_id(req_id), .req_tex(req_tex), .req_wrbk(req_wrbk),
        .part_full(part_full), .rop_full(rop_full),
        .cache_req_valid(cache_req_valid), .cache_req_id(cache_req_id),
        .cache_req_tex(cache_req_tex), .cache_req_wrbk(cache_req_wrbk),
        .cache_status(cache_status), .cache_wr_sent(cache_wr_sent), .cache_rd_sent(cache_rd_sent),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_full(rsp_full),
        .dram_valid(dram_valid), .dram_id(dram_id), .dram_tex(dram_tex),
        .dram_wrbk(dram_wrbk), .dram_full(dram_full)
    );

    // Cache model: kind 0 = hit, 1 = hit with write sent, 2 = miss accepted
    int kind_tbl   [256];
    int fails_left [256];
    int seen       [256];
    int issue      [256];
    int rlat       [256];
    int dlat       [256];
    string ltag    [256];
    int rsp_q[$];
    int dram_q[$];
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always_comb begin
        cache_rd_sent = 1'b0;
        cache_wr_sent = 1'b0;
        cache_status  = 2'b00;
        if (fails_left[cache_req_id] > 0) begin
            cache_status = 2'b10;
        end else if (kind_tbl[cache_req_id] == 1) begin
            cache_wr_sent = 1'b1;
        end else if (kind_tbl[cache_req_id] == 2) begin
            cache_status = 2'b01;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && cache_req_valid && !rsp_full) begin
            seen[cache_req_id] <= seen[cache_req_id] + 1;
            if (fails_left[cache_req_id] > 0)
                fails_left[cache_req_id] <= fails_left[cache_req_id] - 1;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compares every reply and DRAM push against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                if (rsp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected reply", rsp_id, -1);
                end else begin
                    int e;
                    e = rsp_q.pop_front();
                    check(rsp_id == ID_W'(e), "R5 reply tag order", rsp_id, e);
                    if (rlat[e] >= 0)
                        check(cyc - issue[e] == rlat[e], {ltag[e], " reply latency"},
                              cyc - issue[e], rlat[e]);
                end
            end
            if (dram_valid) begin
                if (dram_q.size() == 0) begin
                    check(1'b0, "R8 unexpected DRAM push", dram_id, -1);
                end else begin
                    int e;
                    e = dram_q.pop_front();
                    check(dram_id == ID_W'(e), "R8 DRAM tag order", dram_id, e);
                    if (dlat[e] >= 0)
                        check(cyc - issue[e] == dlat[e], {ltag[e], " DRAM latency"},
                              cyc - issue[e], dlat[e]);
                end
            end
        end
    end

    // Driver: dest 0 = nothing expected, 1 = reply, 2 = DRAM
    task automatic send(input int id, input bit tex, input bit wrbk,
                        input int dest, input int lat, input string tag);
        req_id    = ID_W'(id);
        req_tex   = tex;
        req_wrbk  = wrbk;
        req_valid = 1'b1;
        while (tex ? part_full : rop_full) @(negedge clk);
        issue[id] = cyc;
        ltag[id]  = tag;
        if (dest == 1) begin
            rlat[id] = lat;
            rsp_q.push_back(id);
        end else if (dest == 2) begin
            dlat[id] = lat;
            dram_q.push_back(id);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        for (int k = 0; k < 400; k++) begin
            if (rsp_q.size() == 0 && dram_q.size() == 0) break;
            @(negedge clk);
        end
        idle(12);
        check(rsp_q.size() == 0 && dram_q.size() == 0, "R8 scoreboard drained",
              rsp_q.size() + dram_q.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            kind_tbl[i] = 0; fails_left[i] = 0; seen[i] = 0;
            issue[i] = 0; rlat[i] = -1; dlat[i] = -1; ltag[i] = "R8";
        end
        idle(3);
        check(part_full == 1'b0 && rop_full == 1'b0, "R9 reset full flags", part_full, 0);
        check(cache_req_valid == 1'b0, "R4 reset no access", cache_req_valid, 0);
        check(rsp_valid == 1'b0 && dram_valid == 1'b0, "R8 reset no pushes",
              rsp_valid | dram_valid, 0);
        rst_n = 1'b1;
        idle(2);

        // R3/R8: cache off, texture bypass reaches DRAM after 2+DL
        send(1, 1'b1, 1'b0, 2, 5, "R3");
        // R2: non-texture adds the ingress delay
        send(2, 1'b0, 1'b0, 2, 9, "R2");
        drain();
        // R2: burst through the ingress delay stays in order
        for (int i = 0; i < 4; i++) send(10 + i, 1'b0, 1'b0, 2, 9, "R2");
        drain();
        // R2/R8: zero latencies still take one cycle per stage
        cfg_rop_lat = 16'd0; cfg_dram_lat = 16'd0;
        send(14, 1'b0, 1'b0, 2, 4, "R8");
        drain();
        cfg_rop_lat = 16'd4; cfg_dram_lat = 16'd3;

        // R1/R5: cache on, texture hit replies next cycle
        cfg_cache_en = 1'b1;
        send(20, 1'b1, 1'b0, 1, 1, "R1");
        // R5: writeback hit dropped without reply
        send(21, 1'b1, 1'b1, 0, 0, "R5");
        // R6: hit with write sent, and accepted miss, give no reply
        kind_tbl[22] = 1; kind_tbl[23] = 2;
        send(22, 1'b1, 1'b0, 0, 0, "R6");
        send(23, 1'b1, 1'b0, 0, 0, "R6");
        drain();
        check(seen[21] == 1, "R5 writeback accessed once", seen[21], 1);
        check(seen[22] == 1 && seen[23] == 1, "R6 single access each", seen[22] + seen[23], 2);
        // R5: non-texture hit after ingress delay
        send(24, 1'b0, 1'b0, 1, 5, "R5");
        drain();

        // R7: two reservation fails then a hit; follower waits behind
        fails_left[25] = 2;
        send(25, 1'b1, 1'b0, 1, 3, "R7");
        send(26, 1'b1, 1'b0, 1, 3, "R7");
        drain();
        check(seen[25] == 3, "R7 retries of failed request", seen[25], 3);

        // R4: no access while reply FIFO is full
        rsp_full = 1'b1;
        send(27, 1'b1, 1'b0, 1, -1, "R4");
        for (int i = 0; i < 5; i++) begin
            check(cache_req_valid == 1'b0, "R4 access held off", cache_req_valid, 0);
            idle(1);
        end
        rsp_full = 1'b0;
        drain();

        // R9: ingress FIFO fills to its depth
        rsp_full = 1'b1;
        for (int i = 0; i < 3; i++) send(30 + i, 1'b1, 1'b0, 1, -1, "R9");
        check(part_full == 1'b0, "R9 not full at depth-1", part_full, 0);
        send(33, 1'b1, 1'b0, 1, -1, "R9");
        check(part_full == 1'b1, "R9 full at depth", part_full, 1);
        rsp_full = 1'b0;
        drain();
        check(part_full == 1'b0, "R9 empty after drain", part_full, 0);

        // R3: texture-only caching splits the traffic
        cfg_tex_only = 1'b1;
        send(40, 1'b0, 1'b0, 2, 9, "R3");
        send(41, 1'b1, 1'b0, 1, 1, "R3");
        drain();
        cfg_tex_only = 1'b0;

        // R8: DRAM backpressure holds all pushes, order kept afterwards
        cfg_cache_en = 1'b0;
        dram_full = 1'b1;
        for (int i = 0; i < 3; i++) send(50 + i, 1'b1, 1'b0, 2, -1, "R8");
        for (int i = 0; i < 12; i++) begin
            check(dram_valid == 1'b0, "R8 held while DRAM full", dram_valid, 0);
            idle(1);
        end
        dram_full = 1'b0;
        drain();

        // R10: latencies stay exact while the 8-bit stamp counter wraps
        for (int i = 0; i < 16; i++) begin
            send(60 + i, 1'b0, 1'b0, 2, 9, "R10");
            idle(19);
        end
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule